// File: doc/BRIEF.md
# Configurable Logic Cell

This block is a small programmable logic cell placed beside a processor's peripherals. Eight external source signals are first brought into the system clock domain. Four selectors each pick one of them. Every selector result is offered to a gating stage both as it is and inverted. Each of four gates ORs together the candidates that software has enabled for it, and can then invert the result. A mode field chooses how the four gate results are combined. The choices are three combinational functions and five state-holding elements that run in the system clock domain.

The combined value can be inverted. It is then registered as the output status, and the status drives the pin output when the pin drive bit is set. Rising and falling transitions of the status can each set a sticky interrupt flag, and any write to the control word clears that flag. Software configures the cell through a synchronous word-wide write port with a combinational read-back.

Register map, 16-bit words. Address 0 is the control word. Address 1 holds the gate inversion bits: bit i inverts gate i. Address 2 holds the selector codes: selector k uses bits 4k+2..4k, and bit 4k+3 is unused. Addresses 3 and 4 hold the gate enable bytes: gate 0 is at address 3 bits 7:0, gate 1 at address 3 bits 15:8, gate 2 at address 4 bits 7:0, and gate 3 at address 4 bits 15:8. Within a gate byte, bit 2k enables the plain output of selector k and bit 2k+1 enables its inverted output.

Top module: `clc_cell`

## Requirements
- R1: Selector k forwards source bit sel_k, where sel_k is the 3-bit code at address 2 bits 4k+2..4k. Sources pass through two synchronizing flops. Address 2 reads back as 0x7777 after 0xFFFF is written to it.
- R2: Each gate outputs the OR of its enabled candidates, using the enable byte layout given above. A gate with no enabled candidate yields 0 before inversion.
- R3: Setting bit i of address 1 inverts gate i. Only bits 3:0 are kept, so writing 0xFFFF reads back 0x000F.
- R4: With gates g0..g3, mode 000 gives (g0&g1)|(g2&g3), mode 001 gives (g0|g1)^(g2|g3), and mode 010 gives g0&g1&g2&g3.
- R5: Mode 011 is a set/reset latch with set = g0|g1 and reset = g2|g3. Set wins when both are active, and the state holds when neither is.
- R6: Modes 100, 101 and 110 update only on a 0-to-1 transition of g0, with g2 as a reset that dominates. Mode 100 loads g1, and g3 forces a set. Mode 101 loads g1^g3. Mode 110 is a JK element with J = g1 and K = g3.
- R7: Mode 111 follows g1 while g0 is 1 and holds while g0 is 0. g2 resets it and takes priority, and g3 sets it.
- R8: While the enable bit (control bit 15) is 0, the status, the pin output and any held state are 0.
- R9: Control bit 5 inverts the combined value before it becomes the status.
- R10: The pin output equals the status when control bit 7 is 1, and is 0 otherwise.
- R11: The control word holds the enable at bit 15, the rising-edge interrupt enable at bit 11, the falling-edge interrupt enable at bit 10, the pin drive enable at bit 7, the read-only status at bit 6, the output inversion at bit 5 and the mode at bits 2:0. Other bits read 0, and every register resets to 0.
- R12: A rising status transition with bit 11 set, or a falling one with bit 10 set, sets the interrupt flag. The flag stays set until a write to address 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the address |
| src_i | input | 8 | External source signals |
| cell_out_o | output | 1 | Pin output of the cell |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
On every cycle the assertions check the following: a disabled cell drives a zero status and pin, and its held state is zero. The interrupt flag sets after a qualifying status edge, holds until a control write, and never rises while the status is steady. The set/reset latch obeys its set input, and the edge-triggered element in mode 100 holds without a g0 rising edge. Only the bench's scenarios can show that each selector code, enable bit position and inversion bit reaches the right gate. The same goes for the truth tables of the combinational modes, the JK toggle, transparent-latch following and register read-back masking.

// File: rtl/clc_pkg.sv
package clc_pkg;
  localparam int NUM_SRC  = 8;
  localparam int NUM_MUX  = 4;
  localparam int NUM_GATE = 4;
  localparam int SEL_W    = $clog2(NUM_SRC);
  localparam int CAND_W   = 2 * NUM_MUX;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_GPOL   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_SEL    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_GEN_LO = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_GEN_HI = 3'd4;

  typedef enum logic [2:0] {
    MODE_ANDOR  = 3'd0,
    MODE_ORXOR  = 3'd1,
    MODE_AND4   = 3'd2,
    MODE_SR     = 3'd3,
    MODE_DFF_SR = 3'd4,
    MODE_DFF2   = 3'd5,
    MODE_JK     = 3'd6,
    MODE_LATCH  = 3'd7
  } clc_mode_e;
endpackage

// File: rtl/clc_sync.sv
module clc_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/clc_gates.sv
module clc_gates #(
  parameter int NSRC  = 8,
  parameter int NMUX  = 4,
  parameter int NGATE = 4,
  localparam int SW   = $clog2(NSRC),
  localparam int CW   = 2 * NMUX
) (
  input  logic [NSRC-1:0]     src_i,
  input  logic [NMUX*SW-1:0]  sel_i,
  input  logic [NGATE*CW-1:0] gen_i,
  input  logic [NGATE-1:0]    gpol_i,
  output logic [NGATE-1:0]    gate_o
);
  logic [NMUX-1:0] mux_out;
  logic [CW-1:0]   cand;

  for (genvar k = 0; k < NMUX; k++) begin : g_mux
    assign mux_out[k]    = src_i[sel_i[k*SW +: SW]];
    assign cand[2*k]     = mux_out[k];
    assign cand[2*k + 1] = ~mux_out[k];
  end

  for (genvar i = 0; i < NGATE; i++) begin : g_gate
    assign gate_o[i] = (|(cand & gen_i[i*CW +: CW])) ^ gpol_i[i];
  end
endmodule

// File: rtl/clc_func.sv
module clc_func
  import clc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] mode_i,
  input  logic [3:0] g_i,
  output logic       f_o
);
  logic q_q, q_d, g0_q, clk_rise, set_s, rst_s;

  assign clk_rise = g_i[0] & ~g0_q;
  assign set_s    = g_i[0] | g_i[1];
  assign rst_s    = g_i[2] | g_i[3];

  always_comb begin
    q_d = q_q;
    if (!en_i) begin
      q_d = 1'b0;
    end else begin
      case (mode_i)
        MODE_SR: begin
          if (set_s)      q_d = 1'b1;
          else if (rst_s) q_d = 1'b0;
        end
        MODE_DFF_SR: begin
          if (g_i[2])        q_d = 1'b0;
          else if (g_i[3])   q_d = 1'b1;
          else if (clk_rise) q_d = g_i[1];
        end
        MODE_DFF2: begin
          if (g_i[2])        q_d = 1'b0;
          else if (clk_rise) q_d = g_i[1] ^ g_i[3];
        end
        MODE_JK: begin
          if (g_i[2]) q_d = 1'b0;
          else if (clk_rise) begin
            case ({g_i[1], g_i[3]})
              2'b10:   q_d = 1'b1;
              2'b01:   q_d = 1'b0;
              2'b11:   q_d = ~q_q;
              default: q_d = q_q;
            endcase
          end
        end
        MODE_LATCH: begin
          if (g_i[2])      q_d = 1'b0;
          else if (g_i[3]) q_d = 1'b1;
          else if (g_i[0]) q_d = g_i[1];
        end
        default: q_d = q_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q  <= 1'b0;
      g0_q <= 1'b0;
    end else begin
      q_q  <= q_d;
      g0_q <= g_i[0];
    end
  end

  always_comb begin
    case (mode_i)
      MODE_ANDOR: f_o = (g_i[0] & g_i[1]) | (g_i[2] & g_i[3]);
      MODE_ORXOR: f_o = (g_i[0] | g_i[1]) ^ (g_i[2] | g_i[3]);
      MODE_AND4:  f_o = &g_i;
      default:    f_o = q_q;
    endcase
  end

  AST_SR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == MODE_SR && set_s) |=> q_q); // R5
  AST_DFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == MODE_DFF_SR && !g_i[2] && !g_i[3] && !(g_i[0] && !g0_q))
      |=> $stable(q_q)); // R6
  AST_OFF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !q_q); // R8
endmodule

// File: rtl/clc_cell.sv
module clc_cell
  import clc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic              cell_out_o,
  output logic              irq_o
);
  localparam int SELS_W = NUM_MUX * SEL_W;
  localparam int GEN_W  = NUM_GATE * CAND_W;
  localparam int HALF_W = GEN_W / 2;

  logic rst_meta_q, rst_n_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  logic en_q, intp_q, intn_q, oe_q, pol_q;
  logic [2:0]          mode_q;
  logic [NUM_GATE-1:0] gpol_q;
  logic [SELS_W-1:0]   sel_q, sel_d;
  logic [GEN_W-1:0]    gen_q, gen_d;
  logic                ctrl_wr;

  assign ctrl_wr = reg_we_i && (reg_addr_i == ADDR_CTRL);

  always_comb begin
    sel_d = sel_q;
    for (int k = 0; k < NUM_MUX; k++) sel_d[k*SEL_W +: SEL_W] = reg_wdata_i[k*4 +: SEL_W];
    gen_d = gen_q;
    if (reg_addr_i == ADDR_GEN_LO) gen_d[HALF_W-1:0]     = reg_wdata_i[HALF_W-1:0];
    if (reg_addr_i == ADDR_GEN_HI) gen_d[GEN_W-1:HALF_W] = reg_wdata_i[HALF_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      en_q <= 1'b0; intp_q <= 1'b0; intn_q <= 1'b0;
      oe_q <= 1'b0; pol_q  <= 1'b0; mode_q <= '0;
      gpol_q <= '0; sel_q <= '0; gen_q <= '0;
    end else if (reg_we_i) begin
      if (ctrl_wr) begin
        en_q   <= reg_wdata_i[15];
        intp_q <= reg_wdata_i[11];
        intn_q <= reg_wdata_i[10];
        oe_q   <= reg_wdata_i[7];
        pol_q  <= reg_wdata_i[5];
        mode_q <= reg_wdata_i[2:0];
      end
      if (reg_addr_i == ADDR_GPOL) gpol_q <= reg_wdata_i[NUM_GATE-1:0];
      if (reg_addr_i == ADDR_SEL)  sel_q  <= sel_d;
      if (reg_addr_i == ADDR_GEN_LO || reg_addr_i == ADDR_GEN_HI) gen_q <= gen_d;
    end
  end

  logic [NUM_SRC-1:0]  src_s;
  logic [NUM_GATE-1:0] gate_v;
  logic                f_v;

  clc_sync #(.W(NUM_SRC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n_q), .d_i(src_i), .q_o(src_s));

  clc_gates #(.NSRC(NUM_SRC), .NMUX(NUM_MUX), .NGATE(NUM_GATE)) u_gates (
    .src_i(src_s), .sel_i(sel_q), .gen_i(gen_q), .gpol_i(gpol_q), .gate_o(gate_v));

  clc_func u_func (
    .clk_i(clk_i), .rst_ni(rst_n_q), .en_i(en_q), .mode_i(mode_q),
    .g_i(gate_v), .f_o(f_v));

  logic status_q, status_d, prev_q, irq_q, irq_d, rise_s, fall_s;

  assign status_d = en_q & (f_v ^ pol_q);
  assign rise_s   = status_q & ~prev_q;
  assign fall_s   = ~status_q & prev_q;

  always_comb begin
    irq_d = irq_q;
    if (ctrl_wr) irq_d = 1'b0;
    if ((intp_q && rise_s) || (intn_q && fall_s)) irq_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      status_q <= 1'b0;
      prev_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      prev_q   <= status_q;
      irq_q    <= irq_d;
    end
  end

  assign cell_out_o = status_q & oe_q;
  assign irq_o      = irq_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_CTRL: begin
        reg_rdata_o[15]  = en_q;
        reg_rdata_o[11]  = intp_q;
        reg_rdata_o[10]  = intn_q;
        reg_rdata_o[7]   = oe_q;
        reg_rdata_o[6]   = status_q;
        reg_rdata_o[5]   = pol_q;
        reg_rdata_o[2:0] = mode_q;
      end
      ADDR_GPOL: reg_rdata_o[NUM_GATE-1:0] = gpol_q;
      ADDR_SEL: begin
        for (int k = 0; k < NUM_MUX; k++) reg_rdata_o[k*4 +: SEL_W] = sel_q[k*SEL_W +: SEL_W];
      end
      ADDR_GEN_LO: reg_rdata_o[HALF_W-1:0] = gen_q[HALF_W-1:0];
      ADDR_GEN_HI: reg_rdata_o[HALF_W-1:0] = gen_q[GEN_W-1:HALF_W];
      default: reg_rdata_o = '0;
    endcase
  end

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    !en_q |=> (!status_q && !cell_out_o)); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (irq_o && !ctrl_wr) |=> irq_o); // R12
  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (intp_q && $rose(status_q)) |=> irq_o); // R12
  AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (intn_q && $fell(status_q)) |=> irq_o); // R12
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (!irq_o && $stable(status_q)) |=> !irq_o); // R12
endmodule

// File: tb/sim_clc_cell.sv
module sim_clc_cell;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  src = '0;
  logic        cell_out, irq;
  int          n_tests = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  clc_cell u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_i(src),
    .cell_out_o(cell_out), .irq_o(irq));

  localparam logic [15:0] EN = 16'h8000, IP = 16'h0800, IN = 16'h0400;
  localparam logic [15:0] OE = 16'h0080, POL = 16'h0020;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [7:0] s);
    @(negedge clk); src = s; settle();
  endtask

  task automatic ident();
    wr(3'd2, 16'h3210); wr(3'd3, 16'h0401); wr(3'd4, 16'h4010); wr(3'd1, 16'h0000);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], v); chk("R11", "reset register", v, 16'h0000);
    end
    chk("R8", "reset pin", {15'd0, cell_out}, 16'd0);
    chk("R12", "reset irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(3'd0, 16'hFFFF); rd(3'd0, v);
    chk("R11", "ctrl readback masked, status read-only", v, 16'h8CA7);
    settle(); rd(3'd0, v);
    chk("R11", "ctrl status bit set", v, 16'h8CE7);
    chk("R10", "pin follows status", {15'd0, cell_out}, 16'd1);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'hFFFF); rd(3'd1, v); chk("R3", "gpol mask", v, 16'h000F);
    wr(3'd2, 16'hFFFF); rd(3'd2, v); chk("R1", "sel mask", v, 16'h7777);
  endtask

  task automatic t_andor();
    ident(); wr(3'd0, EN | OE | 16'd0);
    drive(8'h03); chk("R4", "andor 0011", {15'd0, cell_out}, 16'd1);
    drive(8'h05); chk("R4", "andor 0101", {15'd0, cell_out}, 16'd0);
    drive(8'h0C); chk("R4", "andor 1100", {15'd0, cell_out}, 16'd1);
    wr(3'd0, EN | OE | 16'd1);
    drive(8'h01); chk("R4", "orxor 0001", {15'd0, cell_out}, 16'd1);
    drive(8'h05); chk("R4", "orxor 0101", {15'd0, cell_out}, 16'd0);
    drive(8'h00); chk("R4", "orxor 0000", {15'd0, cell_out}, 16'd0);
  endtask

  task automatic t_select();
    ident(); wr(3'd2, 16'h5555); wr(3'd0, EN | OE | 16'd2);
    drive(8'h20); chk("R1", "all muxes pick src5 high", {15'd0, cell_out}, 16'd1);
    drive(8'hDF); chk("R1", "src5 low others high", {15'd0, cell_out}, 16'd0);
  endtask

  task automatic t_gates();
    ident(); wr(3'd3, 16'h0000); wr(3'd4, 16'h0000); wr(3'd0, EN | OE | 16'd2);
    drive(8'hFF); chk("R2", "empty gates give 0", {15'd0, cell_out}, 16'd1 - 16'd1);
    wr(3'd1, 16'h000F); settle();
    chk("R3", "empty gates inverted", {15'd0, cell_out}, 16'd1);
    wr(3'd3, 16'h0002); wr(3'd1, 16'h000E);
    drive(8'h00); chk("R2", "inverted candidate, src0=0", {15'd0, cell_out}, 16'd1);
    drive(8'h01); chk("R2", "inverted candidate, src0=1", {15'd0, cell_out}, 16'd0);
  endtask

  task automatic t_outctl();
    logic [15:0] v;
    ident(); wr(3'd0, EN | OE | POL | 16'd0);
    drive(8'h03); chk("R9", "inverted output", {15'd0, cell_out}, 16'd0);
    wr(3'd0, EN | 16'd0); settle(); rd(3'd0, v);
    chk("R10", "pin off while status high", {15'd0, cell_out}, 16'd0);
    chk("R11", "status reads high", {15'd0, v[6]}, 16'd1);
    wr(3'd0, OE | 16'd0); settle(); rd(3'd0, v);
    chk("R8", "disabled pin", {15'd0, cell_out}, 16'd0);
    chk("R8", "disabled status", {15'd0, v[6]}, 16'd0);
  endtask

  task automatic t_sr();
    ident(); drive(8'h00); wr(3'd0, EN | OE | 16'd3);
    drive(8'h01); chk("R5", "sr set", {15'd0, cell_out}, 16'd1);
    drive(8'h00); chk("R5", "sr hold 1", {15'd0, cell_out}, 16'd1);
    drive(8'h05); chk("R5", "sr both, set wins", {15'd0, cell_out}, 16'd1);
    drive(8'h04); chk("R5", "sr reset", {15'd0, cell_out}, 16'd0);
    drive(8'h00); chk("R5", "sr hold 0", {15'd0, cell_out}, 16'd0);
  endtask

  task automatic t_dff();
    ident(); drive(8'h00); wr(3'd0, EN | OE | 16'd4);
    drive(8'h02); chk("R6", "d without edge", {15'd0, cell_out}, 16'd0);
    drive(8'h03); chk("R6", "d edge loads 1", {15'd0, cell_out}, 16'd1);
    drive(8'h01); chk("R6", "d held while g0 high", {15'd0, cell_out}, 16'd1);
    drive(8'h00); drive(8'h01); chk("R6", "d edge loads 0", {15'd0, cell_out}, 16'd0);
    drive(8'h08); chk("R6", "d set", {15'd0, cell_out}, 16'd1);
    drive(8'h0C); chk("R6", "d reset dominates", {15'd0, cell_out}, 16'd0);
    wr(3'd0, EN | OE | 16'd5); drive(8'h00);
    drive(8'h03); chk("R6", "d2 1^0 loads 1", {15'd0, cell_out}, 16'd1);
    drive(8'h0A); drive(8'h0B); chk("R6", "d2 1^1 loads 0", {15'd0, cell_out}, 16'd0);
    wr(3'd0, EN | OE | 16'd6); drive(8'h00);
    drive(8'h03); chk("R6", "jk set", {15'd0, cell_out}, 16'd1);
    drive(8'h00); drive(8'h01); chk("R6", "jk hold", {15'd0, cell_out}, 16'd1);
    drive(8'h0A); drive(8'h0B); chk("R6", "jk toggle to 0", {15'd0, cell_out}, 16'd0);
    drive(8'h0A); drive(8'h0B); chk("R6", "jk toggle to 1", {15'd0, cell_out}, 16'd1);
    drive(8'h08); drive(8'h09); chk("R6", "jk clear", {15'd0, cell_out}, 16'd0);
  endtask

  task automatic t_latch();
    ident(); drive(8'h00); wr(3'd0, EN | OE | 16'd7);
    drive(8'h03); chk("R7", "latch open d=1", {15'd0, cell_out}, 16'd1);
    drive(8'h01); chk("R7", "latch open d=0", {15'd0, cell_out}, 16'd0);
    drive(8'h02); chk("R7", "latch closed", {15'd0, cell_out}, 16'd0);
    drive(8'h08); chk("R7", "latch set", {15'd0, cell_out}, 16'd1);
    drive(8'h0C); chk("R7", "latch reset wins", {15'd0, cell_out}, 16'd0);
  endtask

  task automatic t_irq();
    ident(); wr(3'd3, 16'h0001); wr(3'd4, 16'h0000); wr(3'd1, 16'h000E);
    drive(8'h00); wr(3'd0, EN | IP | 16'd2);
    chk("R12", "no irq when steady", {15'd0, irq}, 16'd0);
    drive(8'h01); chk("R12", "rise sets irq", {15'd0, irq}, 16'd1);
    repeat (4) @(negedge clk);
    chk("R12", "irq sticky", {15'd0, irq}, 16'd1);
    wr(3'd0, EN | IP | 16'd2); chk("R12", "write clears irq", {15'd0, irq}, 16'd0);
    drive(8'h00); chk("R12", "fall ignored without enable", {15'd0, irq}, 16'd0);
    wr(3'd0, EN | IN | 16'd2);
    drive(8'h01); chk("R12", "rise ignored without enable", {15'd0, irq}, 16'd0);
    drive(8'h00); chk("R12", "fall sets irq", {15'd0, irq}, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_andor();
    t_select();
    t_gates();
    t_outctl();
    t_sr();
    t_dff();
    t_latch();
    t_irq();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule